// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of a successive-approximation converter. A start pulse launches a conversion. The block clears its trial register and sets the most significant trial bit. It then decides one bit per clock, from the top bit down to bit zero, using a single comparator decision input that reports whether the sampled input is at or above the current trial code. One more cycle copies the finished word into the output latch. An active-low busy flag covers the whole conversion.

The output latch keeps the previous result for the whole conversion, so a host can read old data while a new sample is being converted. After each conversion the block enforces a settling interval for the sample-and-hold. A start that arrives during that interval is remembered and launched as soon as the interval ends. A start that arrives while a conversion is running is discarded. The analog front end, the capacitive DAC and the comparator sit outside the block. The trial code output drives the DAC and the comparator result comes back on the decision input.

Top module: `sar_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, busy_n_o is 1 and result_o is 0 until a conversion completes.
- R2: A start_i pulse seen while the block is idle starts a conversion at that clock edge. busy_n_o is 0 from the next cycle, and the trial register is cleared except for its top bit, so dac_code_o equals 1 followed by W-1 zeros.
- R3: One bit is decided per cycle, from bit W-1 down to bit 0. A decision input of 1 keeps the bit under test and 0 clears it. While bit p is under test, dac_code_o holds the already decided upper bits, a 1 in position p and zeros below.
- R4: busy_n_o stays 0 for exactly W+1 cycles (W decisions plus one load cycle). result_o takes the final word at the same edge where busy_n_o returns to 1.
- R5: result_o does not change while busy_n_o is 0. The previous result stays readable for the whole conversion.
- R6: A start_i pulse during a conversion (busy_n_o = 0) has no effect. The conversion length and result are unchanged, and no extra conversion follows it.
- R7: After busy_n_o returns to 1, no new conversion starts for at least ACQ_CYCLES clock cycles.
- R8: A start_i pulse during the settling interval is held. The conversion it requests begins exactly ACQ_CYCLES cycles after busy_n_o returned to 1.
- R9: Once the settling interval has elapsed, a start_i pulse launches a conversion immediately, as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Conversion request, sampled on each rising clock edge |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above dac_code_o |
| dac_code_o | output | W (12) | Trial code driven to the DAC |
| busy_n_o | output | 1 | Low while a conversion is in progress |
| result_o | output | W (12) | Latched result of the last completed conversion |

## Verification
Each check is tied to the cycle on which the result is due, counted from the start edge. busy_n_o falls one cycle after that edge, and the trial code for bit p appears W-1-p cycles later. busy_n_o rises and result_o updates W+1 cycles after the start edge. A held start launches exactly ACQ_CYCLES cycles after that rise. The bench samples all outputs on the falling clock edge and counts low and high busy samples to compare these distances exactly. A scoreboard queues the input code for each launched conversion and compares it with result_o on every rising busy edge it sees, so each conversion is checked whatever stimulus started it.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_LOAD = 2'd2,
    ST_ACQ  = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch_i,
  input  logic         step_i,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic         last_bit_o
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  logic [W-1:0]  trial_q, trial_d;
  logic [IW-1:0] idx_q, idx_d;

  // next trial word and bit pointer
  always_comb begin
    trial_d = trial_q;
    idx_d   = idx_q;
    if (launch_i) begin
      trial_d        = '0;
      trial_d[W-1]   = 1'b1;
      idx_d          = TOP_IDX;
    end else if (step_i) begin
      trial_d[idx_q] = cmp_i;
      if (idx_q != '0) begin
        trial_d[idx_q - IW'(1)] = 1'b1;
        idx_d                   = idx_q - IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      idx_q   <= '0;
    end else if (launch_i || step_i) begin
      trial_q <= trial_d;
      idx_q   <= idx_d;
    end
  end

  assign trial_o    = trial_q;
  assign last_bit_o = (idx_q == '0);
endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
  parameter int ACQ_CYCLES = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic done_o
);
  localparam int AW = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES + 1) : 1;
  localparam logic [AW-1:0] RELOAD = AW'(ACQ_CYCLES - 1);

  logic [AW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = arm_i || (cnt_q != '0);
    cnt_d  = arm_i ? RELOAD : (cnt_q - AW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_bit_i,
  input  logic acq_done_i,
  output logic launch_o,
  output logic step_o,
  output logic load_o,
  output logic busy_n_o
);
  sar_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       busy_n_q, busy_n_d;

  always_comb begin
    launch_o = ((state_q == ST_IDLE) && start_i) ||
               ((state_q == ST_ACQ) && acq_done_i && (start_i || pend_q));
    step_o   = (state_q == ST_CONV);
    load_o   = (state_q == ST_LOAD);

    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (launch_o)   state_d = ST_CONV;
      ST_CONV: if (last_bit_i) state_d = ST_LOAD;
      ST_LOAD:                 state_d = ST_ACQ;
      ST_ACQ:  if (acq_done_i) state_d = launch_o ? ST_CONV : ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase

    // a request during settling is held, never during conversion
    pend_d = pend_q;
    if (launch_o)                          pend_d = 1'b0;
    else if ((state_q == ST_ACQ) && start_i) pend_d = 1'b1;

    busy_n_d = busy_n_q;
    if (launch_o)    busy_n_d = 1'b0;
    else if (load_o) busy_n_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pend_q   <= 1'b0;
      busy_n_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      pend_q   <= pend_d;
      busy_n_q <= busy_n_d;
    end
  end

  assign busy_n_o = busy_n_q;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int W          = 12,
  parameter int ACQ_CYCLES = 60
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cmp_i,
  output logic [W-1:0] dac_code_o,
  output logic         busy_n_o,
  output logic [W-1:0] result_o
);
  logic [1:0]   rst_sync_q;
  logic         rst_int_n;
  logic         launch, step, load, last_bit, acq_done;
  logic [W-1:0] trial;
  logic [W-1:0] result_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sar_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .last_bit_i (last_bit),
    .acq_done_i (acq_done),
    .launch_o   (launch),
    .step_o     (step),
    .load_o     (load),
    .busy_n_o   (busy_n_o)
  );

  sar_approx_reg #(.W(W)) u_approx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .launch_i   (launch),
    .step_i     (step),
    .cmp_i      (cmp_i),
    .trial_o    (trial),
    .last_bit_o (last_bit)
  );

  sar_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_acq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .arm_i  (load),
    .done_o (acq_done)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) result_q <= '0;
    else if (load)  result_q <= trial;
  end

  assign dac_code_o = trial;
  assign result_o   = result_q;
endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
  parameter int W          = 12,
  parameter int ACQ_CYCLES = 60
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy_n_o,
  input logic [W-1:0] result_o,
  input logic [W-1:0] dac_code_o
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  int   low_cnt_q;
  int   high_cnt_q;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q  <= 0;
      high_cnt_q <= 0;
      seen_q     <= 1'b0;
    end else begin
      low_cnt_q  <= busy_n_o ? 0 : low_cnt_q + 1;
      if (!busy_n_o)                  high_cnt_q <= 0;
      else if (high_cnt_q < ACQ_CYCLES) high_cnt_q <= high_cnt_q + 1;
      seen_q     <= seen_q | ~busy_n_o;
    end
  end

  // R2: a launched conversion starts from a cleared register with the top bit on trial
  p_trial_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n_o) |-> dac_code_o == MSB_ONLY);

  // R4: busy low for W decisions plus one load cycle
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n_o) |-> low_cnt_q == W + 1);

  // R4: latch takes the final decided word when busy returns high
  p_load_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n_o) |-> result_o == $past(dac_code_o));

  // R5: result changes only at the end of a conversion
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> $rose(busy_n_o));

  // R7: settling interval respected before the next launch
  p_acq_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_n_o) && seen_q) |-> high_cnt_q >= ACQ_CYCLES);
endmodule

bind sar_sequencer sar_sequencer_chk #(.W(W), .ACQ_CYCLES(ACQ_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_n_o   (busy_n_o),
  .result_o   (result_o),
  .dac_code_o (dac_code_o)
);

// File: tb/sar_sequencer_bench.sv
module sar_sequencer_bench;
  localparam int W   = 12;
  localparam int ACQ = 60;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         cmp;
  logic [W-1:0] vin;
  logic [W-1:0] dac_code;
  logic         busy_n;
  logic [W-1:0] result;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q[$];
  logic prev_busy_n = 1'b1;

  always #5 clk = ~clk;

  // behavioural comparator: input at or above trial code keeps the bit
  assign cmp = (vin >= dac_code);

  sar_sequencer #(.W(W), .ACQ_CYCLES(ACQ)) u_sar_sequencer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .cmp_i      (cmp),
    .dac_code_o (dac_code),
    .busy_n_o   (busy_n),
    .result_o   (result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: every rising busy edge must deliver the next queued code (R4)
  always @(negedge clk) begin
    if (rst_n && busy_n && !prev_busy_n) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected completion", int'(result), 0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(result == e, "R4 result word", int'(result), int'(e));
      end
    end
    prev_busy_n = busy_n;
  end

  function automatic logic [W-1:0] trial_at(input logic [W-1:0] v, input int p);
    logic [W-1:0] upper_mask;
    upper_mask = ~((W'(1) << (p + 1)) - W'(1));
    if (p == W - 1) upper_mask = '0;
    return (v & upper_mask) | (W'(1) << p);
  endfunction

  // launch from idle and follow the whole conversion
  task automatic conv(input logic [W-1:0] v, input bit glitch);
    logic [W-1:0] old;
    int n;
    old = result;
    @(negedge clk);
    vin = v; start = 1'b1;
    exp_q.push_back(v);
    @(negedge clk);
    start = 1'b0;
    chk(busy_n == 1'b0, "R2/R9 busy low after start", int'(busy_n), 0);
    n = 0;
    while (!busy_n && n < 40) begin
      if (n < W) chk(dac_code == trial_at(v, W - 1 - n), "R3 trial code", int'(dac_code),
                     int'(trial_at(v, W - 1 - n)));
      else if (n == W) chk(dac_code == v, "R3 final word", int'(dac_code), int'(v));
      chk(result == old, "R5 old result held", int'(result), int'(old));
      if (glitch && n == 5) start = 1'b1;
      if (glitch && n == 6) start = 1'b0;
      n++;
      @(negedge clk);
    end
    chk(n == W + 1, "R4 busy length", n, W + 1);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; vin = '0;
    idle(3);
    chk(busy_n == 1'b1, "R1 busy in reset", int'(busy_n), 1);
    chk(result == '0, "R1 result in reset", int'(result), 0);
    rst_n = 1'b1;
    idle(4);
    chk(busy_n == 1'b1, "R1 busy after reset", int'(busy_n), 1);
    chk(result == '0, "R1 result after reset", int'(result), 0);

    // R2 R3 R4 R5: distinct codes and extremes
    conv(12'hA5A, 1'b0); idle(ACQ + 2);
    conv(12'h000, 1'b0); idle(ACQ + 2);
    conv(12'hFFF, 1'b0); idle(ACQ + 2);
    conv(12'h800, 1'b0); idle(ACQ + 2);
    conv(12'h7FF, 1'b0); idle(ACQ + 2);
    conv(12'h001, 1'b0); idle(ACQ + 2);

    // R6: start during conversion ignored, nothing follows
    conv(12'h3C6, 1'b1);
    begin
      int hi;
      hi = 0;
      repeat (ACQ + 10) begin
        if (busy_n) hi++;
        @(negedge clk);
      end
      chk(hi == ACQ + 10, "R6 no extra conversion", hi, ACQ + 10);
    end

    // R7 R8: start right after completion is held for the full interval
    conv(12'h4B1, 1'b0);
    begin
      int m;
      vin = 12'h9E3; start = 1'b1;
      exp_q.push_back(12'h9E3);
      m = 0;
      while (busy_n && m < ACQ + 20) begin
        m++;
        @(negedge clk);
        start = 1'b0;
      end
      chk(m == ACQ, "R7/R8 held start launch distance", m, ACQ);
      chk(dac_code == 12'h800, "R8 held launch clears register", int'(dac_code), 12'h800);
      while (!busy_n) @(negedge clk);
    end

    // R9: after the interval a start launches at once; sweep of computed codes
    for (int i = 0; i < 6; i++) begin
      idle(ACQ + 1 + i);
      conv(W'((i * 1237 + 77) % 4096), 1'b0);
    end

    idle(4);
    chk(exp_q.size() == 0, "R4 all conversions completed", exp_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule